// File: doc/BRIEF.md
# Set-Associative Instruction Cache with Burst Line Refill

This block sits between an instruction fetch port and the read half of an AXI4 master. A fetch presents a byte address. If a valid line in the indexed set carries the matching tag, the addressed bus word is returned in the same cycle. On a miss, the cache holds the fetch with ready low. It then issues a single AXI4 read burst that covers the whole line and writes each returned beat into a way chosen by the victim logic. The fetch is served once the line is present.

The geometry is set at elaboration time: bus width, line size, way count and set count. Way count and set count must be powers of two, and a line must hold at least two bus words. Two more elaboration-time choices exist. The first is the victim policy: pseudo-random, least recently used, or round-robin (first in, first out). The second is the refill burst: an incrementing burst from the line base, or a wrapping burst that starts at the missed word and releases the fetch as soon as that word arrives. Only one miss is outstanding at a time. The block has no write path.

Top module: `icache_top`

## Requirements
- R1: After reset every line is invalid, so the first fetch to any address produces a read request.
- R2: A fetch that hits a valid line with a matching tag sees fetch_ready high in the same cycle it is presented. fetch_data then holds the stored word, and no read request is made.
- R3: A miss drives one read request with the following fields: ar_len = words per line − 1; ar_size = log2(bus bytes); ar_burst = 2'b01 for incrementing or 2'b10 for wrapping. ar_addr is the line base when incrementing, or the word-aligned miss address when wrapping. The request is held stable until ar_ready.
- R4: A refill ends at the beat that carries r_last, or at the beat whose index (counted from 0) equals ar_len, whichever comes first. r_ready is low after that beat.
- R5: r_ready is high only while the refill is waiting for data. It is never high together with ar_valid, and it is low when idle.
- R6: In incrementing mode, beat k is written to word k of the line. The fetch is served from the filled line in the cycle after the final beat. With a slave that accepts the address at once and returns one beat per cycle, that cycle is words+2 cycles after the fetch is first presented.
- R7: In wrapping mode, beat k is written to word (critical word + k) mod words. The fetch is served, with the beat's data, in the cycle the first beat is accepted. That is 2 cycles after presentation under the same slave timing.
- R8: An invalid way in the indexed set is filled before any valid way is replaced.
- R9: With the round-robin policy, a per-set pointer picks the victim and advances on every fill. Hits do not affect it.
- R10: With the LRU policy, the way least recently hit or filled in the set is replaced.
- R11: With the random policy, a free-running LFSR picks the victim way. A line just filled hits on the next fetch to it.
- R12: fetch_ready stays low from the miss until the fetch is served. At most one read request is made per fetch, and fetch_ready is never high while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request present, held until ready |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | Fetch served this cycle |
| fetch_data | output | DATA_W | Fetched word, valid with fetch_ready |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Burst start address |
| ar_len | output | 8 | Beats minus one |
| ar_size | output | 3 | log2 of bytes per beat |
| ar_burst | output | 2 | Burst type (01 incrementing, 10 wrapping) |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted |
| r_data | input | DATA_W | Read data beat |
| r_last | input | 1 | Last beat of burst |

## Verification
A hit is due in the cycle it is presented. Under a slave that accepts at once and streams one beat per cycle, an incrementing miss is due words+2 cycles after presentation, and a wrapping miss 2 cycles after. The bench drives each fetch just after a falling edge and samples fetch_ready one delay later on every falling edge. It counts the elapsed cycles and compares them with these figures. Before each fetch it waits until the slave model has drained its burst, so that every fetch starts from an idle cache. The bench decides hit or miss from the number of address handshakes the slave model has seen.

// File: rtl/icache_pkg.sv
// Shared types for the instruction cache: policy selector, refill states
// and the AXI4 burst type codes.
package icache_pkg;
    typedef enum logic [1:0] {POL_RANDOM = 2'd0, POL_LRU = 2'd1, POL_FIFO = 2'd2} policy_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ADDR = 2'd1, ST_DATA = 2'd2} rstate_e;
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] BURST_WRAP = 2'b10;
endpackage

// File: rtl/icache_tagstore.sv
// Valid bits, tags and line data for all ways. Lookup is combinational
// on the fetch index; writes come from the refill sequencer.
// Assumes SETS and WORDS are powers of two.
module icache_tagstore #(
    parameter int WAYS   = 2,
    parameter int SETS   = 16,
    parameter int WORDS  = 2,
    parameter int TAG_W  = 25,
    parameter int DATA_W = 32,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [WORD_W-1:0] lk_word,
    output logic [WAYS-1:0]   hit_vec,
    output logic [WAYS-1:0]   set_valid,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_en,
    input  logic [TAG_W-1:0]  commit_tag
);
    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
    logic [DATA_W-1:0] data_q  [WAYS][SETS][WORDS];

    // Valid bits: cleared by reset, set when a line's last beat lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (commit_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag capture at line completion.
    always_ff @(posedge clk) begin
        if (commit_en) tag_q[wr_way][wr_set] <= commit_tag;
    end

    // Line data written one beat at a time.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_way][wr_set][wr_word] <= wr_data;
    end

    // Tag compare across ways and hit-way word select.
    always_comb begin
        set_valid = valid_q[lk_set];
        rd_word   = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[lk_set][w] && (tag_q[w][lk_set] == lk_tag);
            if (hit_vec[w]) rd_word = data_q[w][lk_set][lk_word];
        end
    end
endmodule

// File: rtl/icache_victim.sv
// Victim way selection. An invalid way always wins; otherwise the
// elaboration-time policy decides (LFSR, per-set age bits, or per-set
// round-robin pointer). Assumes WAYS is a power of two.
module icache_victim import icache_pkg::*; #(
    parameter int      WAYS   = 2,
    parameter int      SETS   = 16,
    parameter policy_e POLICY = POL_RANDOM,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAYS-1:0]  set_valid,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             fill_en,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] pol_way;
    logic [WAY_W-1:0] inv_way;
    logic             inv_found;

    // Lowest-numbered invalid way in the indexed set.
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
        victim = inv_found ? inv_way : pol_way;
    end

    generate
        if (POLICY == POL_LRU) begin : g_lru
            logic [WAY_W-1:0] age_q [SETS][WAYS];
            // Ages: touched way goes to zero, others saturate upward.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++) age_q[s][w] <= '0;
                end else if (upd_en) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (WAY_W'(w) == upd_way) age_q[upd_set][w] <= '0;
                        else if (age_q[upd_set][w] != WAY_W'(WAYS - 1))
                            age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
                    end
                end
            end
            // Oldest way: lowest index at the saturated age.
            always_comb begin
                pol_way = '0;
                for (int w = WAYS - 1; w >= 0; w--)
                    if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) pol_way = WAY_W'(w);
            end
        end else if (POLICY == POL_FIFO) begin : g_fifo
            logic [WAY_W-1:0] ptr_q [SETS];
            // Round-robin pointer advances on each completed fill.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
                end else if (fill_en) begin
                    ptr_q[upd_set] <= (ptr_q[upd_set] == WAY_W'(WAYS - 1)) ? '0
                                      : ptr_q[upd_set] + 1'b1;
                end
            end
            assign pol_way = ptr_q[set_idx];
        end else begin : g_rand
            logic [15:0] lfsr_q;
            // Free-running XNOR LFSR; all-zero is a legal start state.
            always_ff @(posedge clk) begin
                if (!rst_n) lfsr_q <= '0;
                else lfsr_q <= {lfsr_q[14:0],
                                ~(lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10])};
            end
            assign pol_way = (WAYS > 1) ? lfsr_q[WAY_W-1:0] : '0;
        end
    endgenerate
endmodule

// File: rtl/icache_refill.sv
// Refill sequencer: one AXI4 read burst per miss, beat counter, word
// placement for incrementing or wrapping order, and line completion.
// Assumes a line holds at least two bus words.
module icache_refill import icache_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int WORDS      = 2,
    parameter int BYTE_W     = 2,
    parameter int WAY_W      = 1,
    parameter bit WRAP_BURST = 1'b0,
    localparam int WORD_W = $clog2(WORDS),
    localparam int OFF_W  = BYTE_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WAY_W-1:0]  start_way,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    input  logic              r_valid,
    input  logic              r_last,
    output logic              r_ready,
    output logic              idle,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word,
    output logic              crit,
    output logic              commit,
    output logic [ADDR_W-1:0] line_addr,
    output logic [WAY_W-1:0]  line_way
);
    localparam logic [7:0] LEN = 8'(WORDS - 1);

    rstate_e           state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WAY_W-1:0]  way_q;
    logic [7:0]        beat_q;
    logic              accept;
    logic              final_beat;

    assign accept     = (state_q == ST_DATA) && r_valid;
    assign final_beat = r_last || (beat_q == LEN);

    // Sequencer: capture miss, present address, count data beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            way_q   <= '0;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    addr_q  <= start_addr;
                    way_q   <= start_way;
                    state_q <= ST_ADDR;
                end
                ST_ADDR: if (ar_ready) begin
                    beat_q  <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: if (accept) begin
                    if (final_beat) state_q <= ST_IDLE;
                    else beat_q <= beat_q + 8'd1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request fields and beat placement.
    always_comb begin
        ar_valid  = (state_q == ST_ADDR);
        ar_addr   = WRAP_BURST ? {addr_q[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}
                               : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        ar_len    = LEN;
        ar_size   = 3'(BYTE_W);
        ar_burst  = WRAP_BURST ? BURST_WRAP : BURST_INCR;
        r_ready   = (state_q == ST_DATA);
        idle      = (state_q == ST_IDLE);
        wr_en     = accept;
        wr_word   = WRAP_BURST ? addr_q[BYTE_W +: WORD_W] + beat_q[WORD_W-1:0]
                               : beat_q[WORD_W-1:0];
        crit      = WRAP_BURST && accept && (beat_q == 8'd0);
        commit    = accept && final_beat;
        line_addr = addr_q;
        line_way  = way_q;
    end
endmodule

// File: rtl/icache_top.sv
// Read-only instruction cache top: fetch lookup, miss launch, and the
// return path for hits and critical-word-first refills. Assumes fetch
// requests are held until fetch_ready.
module icache_top import icache_pkg::*; #(
    parameter int      ADDR_W     = 32,
    parameter int      BUS_BYTES  = 4,
    parameter int      DATA_W     = 8 * BUS_BYTES,
    parameter int      LINE_BYTES = 8,
    parameter int      WAYS       = 1,
    parameter int      SETS       = 16,
    parameter policy_e POLICY     = POL_RANDOM,
    parameter bit      WRAP_BURST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [DATA_W-1:0] r_data,
    input  logic              r_last
);
    localparam int WORDS  = LINE_BYTES / BUS_BYTES;
    localparam int BYTE_W = $clog2(BUS_BYTES);
    localparam int WORD_W = $clog2(WORDS);
    localparam int OFF_W  = BYTE_W + WORD_W;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic              idle, wr_en, crit, commit;
    logic              lookup, hit_any, touch, miss_start;
    logic [WORD_W-1:0] wr_word;
    logic [ADDR_W-1:0] rf_addr;
    logic [WAY_W-1:0]  rf_way, victim, hit_way;
    logic [WAYS-1:0]   hit_vec, set_valid;
    logic [DATA_W-1:0] rd_word;
    logic [SET_W-1:0]  lk_set, rf_set;

    assign lk_set     = fetch_addr[OFF_W +: SET_W];
    assign rf_set     = rf_addr[OFF_W +: SET_W];
    assign hit_any    = |hit_vec;
    assign lookup     = idle && fetch_valid;
    assign touch      = lookup && hit_any;
    assign miss_start = lookup && !hit_any;

    // Hit vector to way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    // Fetch return: hit in idle, or critical beat of a wrapping refill.
    always_comb begin
        fetch_ready = touch || crit;
        fetch_data  = crit ? r_data : rd_word;
    end

    icache_tagstore #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_tag(fetch_addr[ADDR_W-1 -: TAG_W]),
        .lk_word(fetch_addr[BYTE_W +: WORD_W]),
        .hit_vec(hit_vec), .set_valid(set_valid), .rd_word(rd_word),
        .wr_en(wr_en), .wr_way(rf_way), .wr_set(rf_set), .wr_word(wr_word),
        .wr_data(r_data), .commit_en(commit),
        .commit_tag(rf_addr[ADDR_W-1 -: TAG_W])
    );

    icache_victim #(
        .WAYS(WAYS), .SETS(SETS), .POLICY(POLICY)
    ) victim_i (
        .clk(clk), .rst_n(rst_n),
        .set_idx(lk_set), .set_valid(set_valid),
        .upd_en(touch || commit),
        .upd_set(commit ? rf_set : lk_set),
        .upd_way(commit ? rf_way : hit_way),
        .fill_en(commit), .victim(victim)
    );

    icache_refill #(
        .ADDR_W(ADDR_W), .WORDS(WORDS), .BYTE_W(BYTE_W), .WAY_W(WAY_W),
        .WRAP_BURST(WRAP_BURST)
    ) refill_i (
        .clk(clk), .rst_n(rst_n),
        .start(miss_start), .start_addr(fetch_addr), .start_way(victim),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
        .r_valid(r_valid), .r_last(r_last), .r_ready(r_ready),
        .idle(idle), .wr_en(wr_en), .wr_word(wr_word), .crit(crit),
        .commit(commit), .line_addr(rf_addr), .line_way(rf_way)
    );
endmodule

// File: rtl/icache_checker.sv
// Port-level protocol properties for icache_top, attached by bind.
module icache_checker #(
    parameter int ADDR_W     = 32,
    parameter int BYTE_W     = 2,
    parameter int OFF_W      = 3,
    parameter bit WRAP_BURST = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic              r_valid,
    input logic              r_ready,
    input logic              r_last
);
    p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));
    p_ar_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> ar_addr[BYTE_W-1:0] == '0);
    p_incr_line_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !WRAP_BURST |-> ar_addr[OFF_W-1:0] == '0);
    p_rready_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_ready |-> !ar_valid);
    p_end_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_ready && r_valid && r_last |=> !r_ready);
    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> fetch_valid);
    p_no_serve_in_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> !fetch_ready);
endmodule

bind icache_top icache_checker #(
    .ADDR_W(ADDR_W), .BYTE_W($clog2(BUS_BYTES)), .OFF_W($clog2(LINE_BYTES)),
    .WRAP_BURST(WRAP_BURST)
) chk_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last)
);

// File: tb/icache_top_tb_top.sv
// Slave model: accepts an address at once, then streams one beat per cycle.
module axi_rd_model #(parameter bit DROP_LAST = 1'b0) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ar_valid,
    input  logic [31:0] ar_addr,
    input  logic [7:0]  ar_len,
    input  logic [2:0]  ar_size,
    input  logic [1:0]  ar_burst,
    output logic        ar_ready,
    output logic        r_valid,
    output logic [31:0] r_data,
    output logic        r_last,
    input  logic        r_ready,
    output logic        busy,
    output logic [31:0] ar_cnt,
    output logic [31:0] last_addr,
    output logic [7:0]  last_len,
    output logic [2:0]  last_size,
    output logic [1:0]  last_burst
);
    logic [7:0]  cnt;
    logic [31:0] mask, addr_k;

    function automatic logic [31:0] memw(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; cnt <= '0; ar_cnt <= '0;
            last_addr <= '0; last_len <= '0; last_size <= '0; last_burst <= '0;
        end else if (!busy && ar_valid) begin
            busy <= 1'b1; cnt <= '0; ar_cnt <= ar_cnt + 1;
            last_addr <= ar_addr; last_len <= ar_len;
            last_size <= ar_size; last_burst <= ar_burst;
        end else if (busy && r_ready) begin
            if (cnt == last_len) busy <= 1'b0;
            else cnt <= cnt + 8'd1;
        end
    end

    always_comb begin
        mask     = 32'((int'(last_len) + 1) * 4 - 1);
        addr_k   = (last_burst == 2'b10)
                 ? ((last_addr & ~mask) | ((last_addr + 32'(cnt) * 4) & mask))
                 : last_addr + 32'(cnt) * 4;
        ar_ready = !busy;
        r_valid  = busy;
        r_data   = memw(addr_k);
        r_last   = busy && (cnt == last_len) && !DROP_LAST;
    end
endmodule

module icache_top_tb_top;
    import icache_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        fv [3];
    logic [31:0] fa [3];
    logic        fr [3];
    logic [31:0] fd [3];
    logic        arv [3], arr [3], rv [3], rr [3], rl [3], mbusy [3];
    logic [31:0] ara [3], rdat [3], arcnt [3], laddr [3];
    logic [7:0]  arl [3], llen [3];
    logic [2:0]  ars [3], lsize [3];
    logic [1:0]  arb [3], lburst [3];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    icache_top #(.LINE_BYTES(8), .WAYS(2), .SETS(4), .POLICY(POL_LRU), .WRAP_BURST(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fv[0]), .fetch_addr(fa[0]),
        .fetch_ready(fr[0]), .fetch_data(fd[0]), .ar_valid(arv[0]), .ar_ready(arr[0]),
        .ar_addr(ara[0]), .ar_len(arl[0]), .ar_size(ars[0]), .ar_burst(arb[0]),
        .r_valid(rv[0]), .r_ready(rr[0]), .r_data(rdat[0]), .r_last(rl[0]));
    icache_top #(.LINE_BYTES(16), .WAYS(2), .SETS(4), .POLICY(POL_FIFO), .WRAP_BURST(1'b1)) dut_f (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fv[1]), .fetch_addr(fa[1]),
        .fetch_ready(fr[1]), .fetch_data(fd[1]), .ar_valid(arv[1]), .ar_ready(arr[1]),
        .ar_addr(ara[1]), .ar_len(arl[1]), .ar_size(ars[1]), .ar_burst(arb[1]),
        .r_valid(rv[1]), .r_ready(rr[1]), .r_data(rdat[1]), .r_last(rl[1]));
    icache_top #(.LINE_BYTES(8), .WAYS(2), .SETS(4), .POLICY(POL_RANDOM), .WRAP_BURST(1'b0)) dut_r (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fv[2]), .fetch_addr(fa[2]),
        .fetch_ready(fr[2]), .fetch_data(fd[2]), .ar_valid(arv[2]), .ar_ready(arr[2]),
        .ar_addr(ara[2]), .ar_len(arl[2]), .ar_size(ars[2]), .ar_burst(arb[2]),
        .r_valid(rv[2]), .r_ready(rr[2]), .r_data(rdat[2]), .r_last(rl[2]));

    axi_rd_model #(.DROP_LAST(1'b0)) mem0 (.clk(clk), .rst_n(rst_n), .ar_valid(arv[0]),
        .ar_addr(ara[0]), .ar_len(arl[0]), .ar_size(ars[0]), .ar_burst(arb[0]),
        .ar_ready(arr[0]), .r_valid(rv[0]), .r_data(rdat[0]), .r_last(rl[0]),
        .r_ready(rr[0]), .busy(mbusy[0]), .ar_cnt(arcnt[0]), .last_addr(laddr[0]),
        .last_len(llen[0]), .last_size(lsize[0]), .last_burst(lburst[0]));
    axi_rd_model #(.DROP_LAST(1'b1)) mem1 (.clk(clk), .rst_n(rst_n), .ar_valid(arv[1]),
        .ar_addr(ara[1]), .ar_len(arl[1]), .ar_size(ars[1]), .ar_burst(arb[1]),
        .ar_ready(arr[1]), .r_valid(rv[1]), .r_data(rdat[1]), .r_last(rl[1]),
        .r_ready(rr[1]), .busy(mbusy[1]), .ar_cnt(arcnt[1]), .last_addr(laddr[1]),
        .last_len(llen[1]), .last_size(lsize[1]), .last_burst(lburst[1]));
    axi_rd_model #(.DROP_LAST(1'b0)) mem2 (.clk(clk), .rst_n(rst_n), .ar_valid(arv[2]),
        .ar_addr(ara[2]), .ar_len(arl[2]), .ar_size(ars[2]), .ar_burst(arb[2]),
        .ar_ready(arr[2]), .r_valid(rv[2]), .r_data(rdat[2]), .r_last(rl[2]),
        .r_ready(rr[2]), .busy(mbusy[2]), .ar_cnt(arcnt[2]), .last_addr(laddr[2]),
        .last_len(llen[2]), .last_size(lsize[2]), .last_burst(lburst[2]));

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] w = {a[31:2], 2'b00};
        return {w[15:0] ^ 16'hC3A5, w[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One fetch on cache u; exp_miss: 1 miss, 0 hit, -1 either.
    task automatic do_fetch(input int u, input logic [31:0] a, input int exp_miss,
                            input string req);
        int c0, cyc, miss, lat;
        logic rdy;
        logic [31:0] got;
        @(negedge clk);
        while (mbusy[u]) @(negedge clk);
        c0 = int'(arcnt[u]);
        fv[u] = 1'b1; fa[u] = a; #1;
        cyc = 0;
        while (!fr[u] && cyc < 100) begin @(negedge clk); #1; cyc++; end
        rdy = fr[u]; got = fd[u];
        @(posedge clk); #1;
        fv[u] = 1'b0;
        miss = int'(arcnt[u]) - c0;
        chk(rdy, req, "fetch served", longint'(rdy), 1);
        chk(got == exp_word(a), req, "fetch data", got, exp_word(a));
        if (exp_miss >= 0) chk(miss == exp_miss, req, "read requests", miss, exp_miss);
        chk(miss <= 1, "R12", "requests per fetch", miss, 1);
        lat = (miss == 0) ? 0 : ((u == 1) ? 2 : 4);
        chk(cyc == lat, req, "cycles to ready", cyc, lat);
    endtask

    function automatic logic [31:0] a8(input int tag, input int set, input int w);
        return 32'((tag << 5) | (set << 3) | (w << 2));
    endfunction
    function automatic logic [31:0] a16(input int tag, input int set, input int w);
        return 32'((tag << 6) | (set << 4) | (w << 2));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < 3; u++) begin fv[u] = 1'b0; fa[u] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        for (int u = 0; u < 3; u++) begin
            chk(!rr[u] && !arv[u], "R5", "idle r_ready/ar_valid after reset", {rr[u], arv[u]}, 0);
            chk(!fr[u], "R12", "no ready without request", longint'(fr[u]), 0);
        end

        // LRU / incrementing cache: fill two ways in every set.
        for (int t = 1; t <= 2; t++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++)
                    do_fetch(0, a8(t, s, w), (w == 0) ? 1 : 0, (t == 1) ? "R1/R6" : "R8");
        for (int t = 1; t <= 2; t++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++)
                    do_fetch(0, a8(t, s, w), 0, "R2/R8");
        do_fetch(0, a8(1, 0, 0), 0, "R10");
        do_fetch(0, a8(3, 0, 1), 1, "R10");
        chk(laddr[0] == a8(3, 0, 0), "R3", "incr ar_addr", laddr[0], a8(3, 0, 0));
        chk(llen[0] == 8'd1, "R3", "incr ar_len", llen[0], 1);
        chk(lsize[0] == 3'd2, "R3", "ar_size", lsize[0], 2);
        chk(lburst[0] == 2'b01, "R3", "incr ar_burst", lburst[0], 1);
        do_fetch(0, a8(3, 0, 0), 0, "R6");
        do_fetch(0, a8(1, 0, 1), 0, "R10");
        do_fetch(0, a8(2, 0, 0), 1, "R10");
        do_fetch(0, a8(3, 0, 0), 1, "R10");

        // Round-robin / wrapping cache, slave never raises r_last.
        for (int c = 0; c < 4; c++) begin
            do_fetch(1, a16(1, c, c), 1, "R7");
            chk(laddr[1] == a16(1, c, c), "R3", "wrap ar_addr", laddr[1], a16(1, c, c));
            chk(llen[1] == 8'd3 && lburst[1] == 2'b10, "R3", "wrap len/burst",
                {llen[1], lburst[1]}, {8'd3, 2'b10});
            @(negedge clk);
            while (mbusy[1]) @(negedge clk);
            #1;
            chk(!rr[1], "R4", "r_ready low after counted end", longint'(rr[1]), 0);
            for (int w = 0; w < 4; w++) do_fetch(1, a16(1, c, w), 0, "R7");
        end
        do_fetch(1, a16(2, 0, 0), 1, "R8");
        do_fetch(1, a16(1, 0, 3), 0, "R9");
        do_fetch(1, a16(3, 0, 1), 1, "R9");
        do_fetch(1, a16(2, 0, 2), 0, "R9");
        do_fetch(1, a16(1, 0, 0), 1, "R9");

        // Random cache: cycle many tags through one set.
        for (int rep = 0; rep < 3; rep++)
            for (int t = 1; t <= 6; t++) begin
                do_fetch(2, a8(t, 1, 0), -1, "R11");
                do_fetch(2, a8(t, 1, 1), 0, "R11");
                do_fetch(2, a8(t, 1, 0), 0, "R11");
            end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule